// File: doc/BRIEF.md
# Packetized DRAM Transaction Request Sequencer

This block sits on the controller side of a packet-based DRAM link. It accepts one memory transaction at a time over a valid/ready handshake. A transaction is a read or write to one bank and row, with two column addresses. The block turns it into a fixed, timed series of request packets on a command bus: a row activate, two column accesses, then a bank precharge. It emits at most one packet per clock cycle, and every idle cycle carries an explicit no-operation code.

Data packets on the data bus lag their column commands by a fixed latency. The sequencer raises a strobe in each cycle where a data packet belongs to the current transaction. For writes, the strobe marks the cycle in which the write data must be driven. For reads, it marks the cycle in which returning data must be captured. A select bit tells which of the two column accesses the packet belongs to.

All spacings are parameters: row-to-column delay for reads and for writes, column-to-column spacing, write and read data latency, and column-to-precharge delay for reads and for writes. The defaults match the cycle counts listed below. A new transaction is taken only when the previous one has issued its precharge and its last data strobe.

Top module: `pkt_req_sequencer`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of a transaction, `txn_ready` is 1, `req_op` is NOP (3'b000), all request fields are 0 and both strobes are 0.
- R2: The cycle after a handshake (`txn_valid` and `txn_ready` both 1 at a clock edge) carries ACT (3'b001) with the transaction's bank and row, and `req_col` 0.
- R3: For a write, WR (3'b011) carrying {bank, first column} is issued 1 cycle after ACT, and WR carrying {bank, second column} follows 2 cycles later. `req_row` is 0 on both.
- R4: For a write, `wr_data_stb` is 1 exactly 3 cycles after each WR. `data_sel` is 0 for the first column's packet and 1 for the second.
- R5: For a write, PRE (3'b100) carrying only the bank (row and column 0) is issued 10 cycles after the second WR.
- R6: For a read, RD (3'b010) carrying {bank, first column} is issued 5 cycles after ACT, and RD carrying {bank, second column} follows 2 cycles later.
- R7: For a read, `rd_capture_stb` is 1 exactly 6 cycles after each RD, with `data_sel` 0 then 1. The two strobes are never 1 together.
- R8: For a read, PRE carrying only the bank is issued 3 cycles after the second RD. This is before the second read data packet arrives.
- R9: In every cycle with no scheduled packet, `req_op` is NOP with all fields 0. In every cycle with no scheduled data packet, both strobes are 0.
- R10: `txn_ready` is 0 from the cycle after a handshake through the cycle holding the later of the precharge and the last data strobe, then returns to 1. While it is 0, `txn_valid` and the transaction inputs have no effect.
- R11: A transaction offered while busy is accepted in the first cycle `txn_ready` returns to 1. Its ACT follows in the next cycle, and no two packets ever share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Sequencer idle and able to take a transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_bank | input | 3 | Bank address |
| txn_row | input | 11 | Row address |
| txn_col0 | input | 10 | First column address |
| txn_col1 | input | 10 | Second column address |
| req_op | output | 3 | Packet opcode: NOP 000, ACT 001, RD 010, WR 011, PRE 100 |
| req_bank | output | 3 | Packet bank field |
| req_row | output | 11 | Packet row field (ACT only) |
| req_col | output | 10 | Packet column field (RD/WR only) |
| wr_data_stb | output | 1 | Drive write data packet this cycle |
| rd_capture_stb | output | 1 | Capture read data packet this cycle |
| data_sel | output | 1 | Column access the data packet belongs to |

## Verification
The hardest situation to reach from the ports is a transaction that arrives while another is still running. The block must hold off the waiting one with its differing fields, take it in exactly the cycle the first one ends, and leave no trace of it before then. The stimulus reaches this by starting the next transfer as soon as the previous handshake is done, so `txn_valid` stays high with new addresses across the whole busy window. A reset dropped into the middle of a read checks the other way out of a transaction. The scoreboard predicts every packet and strobe cycle from the stated offsets. In every other cycle it expects NOP and quiet strobes.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'b000,
    OP_ACT = 3'b001,
    OP_RD  = 3'b010,
    OP_WR  = 3'b011,
    OP_PRE = 3'b100
  } req_op_e;

  // Cycle (relative to ACT) of a column access; second selects the later one.
  function automatic int col_slot(input bit wr, input bit second,
                                  input int rcd_w, input int rcd_r, input int cc);
    return (wr ? rcd_w : rcd_r) + (second ? cc : 0);
  endfunction

  // Cycle of the data packet that belongs to a column access.
  function automatic int data_slot(input bit wr, input bit second,
                                   input int rcd_w, input int rcd_r, input int cc,
                                   input int cwd, input int cac);
    return col_slot(wr, second, rcd_w, rcd_r, cc) + (wr ? cwd : cac);
  endfunction

  // Cycle of the precharge, counted from the second column access.
  function automatic int pre_slot(input bit wr,
                                  input int rcd_w, input int rcd_r, input int cc,
                                  input int wrp, input int rdp);
    return col_slot(wr, 1'b1, rcd_w, rcd_r, cc) + (wr ? wrp : rdp);
  endfunction

  // Last busy cycle: the later of precharge and final data packet.
  function automatic int last_slot(input bit wr,
                                   input int rcd_w, input int rcd_r, input int cc,
                                   input int cwd, input int cac,
                                   input int wrp, input int rdp);
    int p;
    int d;
    p = pre_slot(wr, rcd_w, rcd_r, cc, wrp, rdp);
    d = data_slot(wr, 1'b1, rcd_w, rcd_r, cc, cwd, cac);
    return (p > d) ? p : d;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_txn_latch.sv
module seq_txn_latch #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_write,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col0,
  input  logic [COL_W-1:0]  in_col1,
  output logic              q_write,
  output logic [BANK_W-1:0] q_bank,
  output logic [ROW_W-1:0]  q_row,
  output logic [COL_W-1:0]  q_col0,
  output logic [COL_W-1:0]  q_col1
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col0  <= '0;
      q_col1  <= '0;
    end else if (load) begin
      q_write <= in_write;
      q_bank  <= in_bank;
      q_row   <= in_row;
      q_col0  <= in_col0;
      q_col1  <= in_col1;
    end
  end

endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int LAST_WR = 13,
  parameter int LAST_RD = 13,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  output logic          busy,
  output logic [CW-1:0] step,
  output logic          final_step
);

  localparam logic [CW-1:0] END_WR = CW'(LAST_WR);
  localparam logic [CW-1:0] END_RD = CW'(LAST_RD);

  logic [CW-1:0] end_step;
  assign end_step   = is_write ? END_WR : END_RD;
  assign final_step = busy && (step == end_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (final_step) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R1: an idle timer rests at step zero
  a_r1_idle_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> step == '0);

  // R10: the step never runs past the transaction's final slot
  a_r10_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step <= end_step);

  // R10: a finished transaction leaves the timer idle
  a_r10_idle_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (final_step && !start) |=> !busy);

endmodule

// File: rtl/seq_pkt_encoder.sv
module seq_pkt_encoder
  import pkt_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int CW     = 4,
  parameter int RCD_W  = 1,
  parameter int RCD_R  = 5,
  parameter int CC     = 2,
  parameter int WRP    = 10,
  parameter int RDP    = 3
) (
  input  logic              busy,
  input  logic [CW-1:0]     step,
  input  logic              is_write,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col0,
  input  logic [COL_W-1:0]  col1,
  output logic [2:0]        op,
  output logic [BANK_W-1:0] op_bank,
  output logic [ROW_W-1:0]  op_row,
  output logic [COL_W-1:0]  op_col,
  output logic              ev_act,
  output logic              ev_col0,
  output logic              ev_col1,
  output logic              ev_pre
);

  localparam logic [CW-1:0] C0_WR  = CW'(col_slot(1'b1, 1'b0, RCD_W, RCD_R, CC));
  localparam logic [CW-1:0] C1_WR  = CW'(col_slot(1'b1, 1'b1, RCD_W, RCD_R, CC));
  localparam logic [CW-1:0] C0_RD  = CW'(col_slot(1'b0, 1'b0, RCD_W, RCD_R, CC));
  localparam logic [CW-1:0] C1_RD  = CW'(col_slot(1'b0, 1'b1, RCD_W, RCD_R, CC));
  localparam logic [CW-1:0] PRE_WR = CW'(pre_slot(1'b1, RCD_W, RCD_R, CC, WRP, RDP));
  localparam logic [CW-1:0] PRE_RD = CW'(pre_slot(1'b0, RCD_W, RCD_R, CC, WRP, RDP));

  logic [CW-1:0] c0_at;
  logic [CW-1:0] c1_at;
  logic [CW-1:0] pre_at;

  assign c0_at  = is_write ? C0_WR  : C0_RD;
  assign c1_at  = is_write ? C1_WR  : C1_RD;
  assign pre_at = is_write ? PRE_WR : PRE_RD;

  assign ev_act  = busy && (step == '0);
  assign ev_col0 = busy && (step == c0_at);
  assign ev_col1 = busy && (step == c1_at);
  assign ev_pre  = busy && (step == pre_at);

  always_comb begin
    op      = OP_NOP;
    op_bank = '0;
    op_row  = '0;
    op_col  = '0;
    if (ev_act) begin
      op      = OP_ACT;
      op_bank = bank;
      op_row  = row;
    end else if (ev_col0 || ev_col1) begin
      op      = is_write ? OP_WR : OP_RD;
      op_bank = bank;
      op_col  = ev_col1 ? col1 : col0;
    end else if (ev_pre) begin
      op      = OP_PRE;
      op_bank = bank;
    end
  end

  // R11: at most one packet event per cycle (holds for legal parameter sets)
  always_comb begin
    a_r11_one_packet: assert ($onehot0({ev_act, ev_col0, ev_col1, ev_pre}));
  end

endmodule

// File: rtl/seq_data_window.sv
module seq_data_window
  import pkt_seq_pkg::*;
#(
  parameter int CW    = 4,
  parameter int RCD_W = 1,
  parameter int RCD_R = 5,
  parameter int CC    = 2,
  parameter int CWD   = 3,
  parameter int CAC   = 6
) (
  input  logic          busy,
  input  logic [CW-1:0] step,
  input  logic          is_write,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic          sel
);

  localparam logic [CW-1:0] D0_WR = CW'(data_slot(1'b1, 1'b0, RCD_W, RCD_R, CC, CWD, CAC));
  localparam logic [CW-1:0] D1_WR = CW'(data_slot(1'b1, 1'b1, RCD_W, RCD_R, CC, CWD, CAC));
  localparam logic [CW-1:0] D0_RD = CW'(data_slot(1'b0, 1'b0, RCD_W, RCD_R, CC, CWD, CAC));
  localparam logic [CW-1:0] D1_RD = CW'(data_slot(1'b0, 1'b1, RCD_W, RCD_R, CC, CWD, CAC));

  logic hit0;
  logic hit1;

  assign hit0   = busy && (step == (is_write ? D0_WR : D0_RD));
  assign hit1   = busy && (step == (is_write ? D1_WR : D1_RD));
  assign wr_stb = is_write && (hit0 || hit1);
  assign rd_stb = !is_write && (hit0 || hit1);
  assign sel    = hit1;

endmodule

// File: rtl/pkt_req_sequencer.sv
module pkt_req_sequencer
  import pkt_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int RCD_W  = 1,   // activate to first write
  parameter int RCD_R  = 5,   // activate to first read
  parameter int CC     = 2,   // column to column
  parameter int CWD    = 3,   // write command to write data
  parameter int CAC    = 6,   // read command to read data
  parameter int WRP    = 10,  // second write to precharge
  parameter int RDP    = 3    // second read to precharge
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic              txn_write,
  input  logic [BANK_W-1:0] txn_bank,
  input  logic [ROW_W-1:0]  txn_row,
  input  logic [COL_W-1:0]  txn_col0,
  input  logic [COL_W-1:0]  txn_col1,
  output logic [2:0]        req_op,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [COL_W-1:0]  req_col,
  output logic              wr_data_stb,
  output logic              rd_capture_stb,
  output logic              data_sel
);

  localparam int LAST_WR = last_slot(1'b1, RCD_W, RCD_R, CC, CWD, CAC, WRP, RDP);
  localparam int LAST_RD = last_slot(1'b0, RCD_W, RCD_R, CC, CWD, CAC, WRP, RDP);
  localparam int CW      = $clog2(max2(LAST_WR, LAST_RD) + 1);

  logic              accept;
  logic              busy;
  logic              final_step;
  logic [CW-1:0]     step;
  logic              q_write;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col0;
  logic [COL_W-1:0]  q_col1;
  logic              ev_act;
  logic              ev_col0;
  logic              ev_col1;
  logic              ev_pre;

  assign txn_ready = !busy;
  assign accept    = txn_valid && txn_ready;

  seq_txn_latch #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_write(txn_write), .in_bank(txn_bank), .in_row(txn_row),
    .in_col0(txn_col0), .in_col1(txn_col1),
    .q_write(q_write), .q_bank(q_bank), .q_row(q_row),
    .q_col0(q_col0), .q_col1(q_col1)
  );

  seq_step_timer #(.LAST_WR(LAST_WR), .LAST_RD(LAST_RD), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .is_write(q_write),
    .busy(busy), .step(step), .final_step(final_step)
  );

  seq_pkt_encoder #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CW(CW),
    .RCD_W(RCD_W), .RCD_R(RCD_R), .CC(CC), .WRP(WRP), .RDP(RDP)
  ) u_enc (
    .busy(busy), .step(step), .is_write(q_write),
    .bank(q_bank), .row(q_row), .col0(q_col0), .col1(q_col1),
    .op(req_op), .op_bank(req_bank), .op_row(req_row), .op_col(req_col),
    .ev_act(ev_act), .ev_col0(ev_col0), .ev_col1(ev_col1), .ev_pre(ev_pre)
  );

  seq_data_window #(
    .CW(CW), .RCD_W(RCD_W), .RCD_R(RCD_R), .CC(CC), .CWD(CWD), .CAC(CAC)
  ) u_win (
    .busy(busy), .step(step), .is_write(q_write),
    .wr_stb(wr_data_stb), .rd_stb(rd_capture_stb), .sel(data_sel)
  );

  // R2: a handshake is followed at once by an activate with the offered bank
  a_r2_act_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_op == OP_ACT) && (req_bank == $past(txn_bank)) && (req_row == $past(txn_row)));

  // R10: an offer while busy starts nothing
  a_r10_busy_offer_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready && !final_step) |=> !ev_act);

  // R7: write and read data windows never coincide
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data_stb, rd_capture_stb}));

  // R5, R8: precharge carries the bank only
  a_r5_pre_bank_only: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> (req_row == '0) && (req_col == '0));

  // R10: data strobes and packets only while not ready
  a_r10_activity_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_stb || rd_capture_stb || req_op != OP_NOP) |-> !txn_ready);

  // R1: the precharge is the last packet of its transaction
  a_r1_pre_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |=> !ev_col0 && !ev_col1);

endmodule

// File: tb/tb_pkt_req_sequencer.sv
module tb_pkt_req_sequencer;

  // Offsets from ACT, restated from the requirements
  localparam int W_C0 = 1,  W_C1 = 3,  W_D0 = 4,  W_D1 = 6,  W_PRE = 13, W_END = 13;
  localparam int R_C0 = 5,  R_C1 = 7,  R_D0 = 11, R_D1 = 13, R_PRE = 10, R_END = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic        txn_write = 1'b0;
  logic [2:0]  txn_bank = '0;
  logic [10:0] txn_row = '0;
  logic [9:0]  txn_col0 = '0;
  logic [9:0]  txn_col1 = '0;
  logic [2:0]  req_op;
  logic [2:0]  req_bank;
  logic [10:0] req_row;
  logic [9:0]  req_col;
  logic        wr_data_stb;
  logic        rd_capture_stb;
  logic        data_sel;

  pkt_req_sequencer dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          cyc;
    logic [2:0]  op;
    logic [2:0]  bank;
    logic [10:0] row;
    logic [9:0]  col;
    string       tag;
  } cmd_item_t;

  typedef struct {
    int    cyc;
    bit    wr;
    bit    sel;
    string tag;
  } dat_item_t;

  cmd_item_t cmd_q[$];
  dat_item_t dat_q[$];

  int cyc = 0;
  int busy_end = -100;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic cmd_item_t mk_cmd(int c, logic [2:0] op, logic [2:0] b,
                                       logic [10:0] r, logic [9:0] col, string tag);
    cmd_item_t it;
    it.cyc = c; it.op = op; it.bank = b; it.row = r; it.col = col; it.tag = tag;
    return it;
  endfunction

  function automatic dat_item_t mk_dat(int c, bit wr, bit sel, string tag);
    dat_item_t it;
    it.cyc = c; it.wr = wr; it.sel = sel; it.tag = tag;
    return it;
  endfunction

  // Driver: called at a falling edge; holds the offer until accepted
  task automatic send(input bit wr, input logic [2:0] b, input logic [10:0] r,
                      input logic [9:0] c0, input logic [9:0] c1);
    int t0;
    txn_valid = 1'b1; txn_write = wr; txn_bank = b; txn_row = r;
    txn_col0 = c0; txn_col1 = c1;
    while (!txn_ready) @(negedge clk);
    t0 = cyc + 1;
    cmd_q.push_back(mk_cmd(t0, 3'b001, b, r, '0, "R2"));
    if (wr) begin
      cmd_q.push_back(mk_cmd(t0 + W_C0, 3'b011, b, '0, c0, "R3"));
      cmd_q.push_back(mk_cmd(t0 + W_C1, 3'b011, b, '0, c1, "R3"));
      cmd_q.push_back(mk_cmd(t0 + W_PRE, 3'b100, b, '0, '0, "R5"));
      dat_q.push_back(mk_dat(t0 + W_D0, 1'b1, 1'b0, "R4"));
      dat_q.push_back(mk_dat(t0 + W_D1, 1'b1, 1'b1, "R4"));
      busy_end = t0 + W_END;
    end else begin
      cmd_q.push_back(mk_cmd(t0 + R_C0, 3'b010, b, '0, c0, "R6"));
      cmd_q.push_back(mk_cmd(t0 + R_C1, 3'b010, b, '0, c1, "R6"));
      cmd_q.push_back(mk_cmd(t0 + R_PRE, 3'b100, b, '0, '0, "R8"));
      dat_q.push_back(mk_dat(t0 + R_D0, 1'b0, 1'b0, "R7"));
      dat_q.push_back(mk_dat(t0 + R_D1, 1'b0, 1'b1, "R7"));
      busy_end = t0 + R_END;
    end
    @(negedge clk);
    txn_valid = 1'b0;
    txn_bank = ~b; txn_row = ~r;
  endtask

  // Monitor: samples a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_en && rst_n && !done) begin
        cmd_item_t ec;
        dat_item_t ed;
        bit exp_wr;
        bit exp_rd;
        bit exp_sel;
        string dtag;
        ec = mk_cmd(cyc, 3'b000, '0, '0, '0, "R9");
        if (cmd_q.size() > 0 && cmd_q[0].cyc < cyc) begin
          check(1'b0, cmd_q[0].tag, "missed packet", 0, cmd_q[0].op);
          void'(cmd_q.pop_front());
        end
        if (cmd_q.size() > 0 && cmd_q[0].cyc == cyc) ec = cmd_q.pop_front();
        check(req_op == ec.op, ec.tag, "req_op", req_op, ec.op);
        check(req_bank == ec.bank, ec.tag, "req_bank", req_bank, ec.bank);
        check(req_row == ec.row, ec.tag, "req_row", req_row, ec.row);
        check(req_col == ec.col, ec.tag, "req_col", req_col, ec.col);

        exp_wr = 1'b0; exp_rd = 1'b0; exp_sel = 1'b0; dtag = "R9";
        if (dat_q.size() > 0 && dat_q[0].cyc == cyc) begin
          ed = dat_q.pop_front();
          exp_wr = ed.wr; exp_rd = !ed.wr; exp_sel = ed.sel; dtag = ed.tag;
        end
        check(wr_data_stb == exp_wr, dtag, "wr_data_stb", wr_data_stb, exp_wr);
        check(rd_capture_stb == exp_rd, dtag, "rd_capture_stb", rd_capture_stb, exp_rd);
        if (exp_wr || exp_rd)
          check(data_sel == exp_sel, dtag, "data_sel", data_sel, exp_sel);

        check(txn_ready == (cyc > busy_end), "R10", "txn_ready", txn_ready, cyc > busy_end);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(txn_ready == 1'b1, "R1", "txn_ready after reset", txn_ready, 1);
    check(req_op == 3'b000, "R1", "req_op after reset", req_op, 0);
    check(!wr_data_stb && !rd_capture_stb, "R1", "strobes after reset",
          {wr_data_stb, rd_capture_stb}, 0);
    mon_en = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 R5: single write
    send(1'b1, 3'd2, 11'h155, 10'h0AA, 10'h155);
    repeat (16) @(negedge clk);
    // R6 R7 R8: single read
    send(1'b0, 3'd5, 11'h2AB, 10'h3C3, 10'h03C);
    repeat (16) @(negedge clk);

    // R10 R11: back-to-back offers held through busy windows, extreme fields
    send(1'b1, 3'd7, 11'h7FF, 10'h3FF, 10'h000);
    send(1'b0, 3'd0, 11'h000, 10'h000, 10'h3FF);
    send(1'b0, 3'd7, 11'h7FF, 10'h3FF, 10'h3FF);
    send(1'b1, 3'd1, 11'h001, 10'h001, 10'h200);
    repeat (18) @(negedge clk);

    // R1: reset in the middle of a read
    send(1'b0, 3'd3, 11'h333, 10'h111, 10'h222);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    cmd_q.delete();
    dat_q.delete();
    busy_end = -100;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txn_ready == 1'b1, "R1", "txn_ready after mid reset", txn_ready, 1);
    check(req_op == 3'b000, "R1", "req_op after mid reset", req_op, 0);
    check(!rd_capture_stb, "R1", "capture strobe after mid reset", rd_capture_stb, 0);
    repeat (16) @(negedge clk);

    // R2 R11: transaction after the reset proceeds normally
    send(1'b1, 3'd4, 11'h444, 10'h123, 10'h321);
    repeat (18) @(negedge clk);
    check(cmd_q.size() == 0, "R11", "packets left unseen", cmd_q.size(), 0);
    check(dat_q.size() == 0, "R7", "data windows left unseen", dat_q.size(), 0);
    finish_run();
  end

endmodule